// File: doc/BRIEF.md
# Cascaded Pending-and-Mask Interrupt Controller

This block collects interrupt requests from 32 main sources and from 11 secondary sources. It presents one of them at a time to a processor through a single interrupt line. Each main request is caught in a source-pending register. A main mask decides which caught requests may compete. The lowest-numbered candidate is moved into a one-hot interrupt-pending register, and its bit number goes into an offset register, so the handler can find it in one read.

The secondary sources are caught in their own sub-pending register and filtered by a sub-mask. They are bundled in groups of three, with a last group of two. Each group drives one shared main line. Software services an interrupt by reading the offset, clearing the sub-pending bit if there is one, then the source-pending bit, and last the interrupt-pending bit. Every pending register is cleared by writing ones to it. A small synchronous register bus gives access to all the state.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, the main mask and the sub-mask read as all ones. Source-pending, interrupt-pending, sub-pending and offset read as zero, and `irq` is low.
- R2: A main request bit that is high at a clock edge sets its source-pending bit. The bit stays set until software clears it, even when the request has already gone away.
- R3: Writing a 1 to a bit of source-pending (address 0), interrupt-pending (address 2) or sub-pending (address 4) clears that bit. A 0 in the written word leaves the bit unchanged, and an all-ones word clears every bit. A request arriving in the same cycle as the clear wins, so the bit stays set.
- R4: A source-pending bit whose main mask bit (address 1, 1 = masked) is set is still latched, but it never reaches interrupt-pending.
- R5: When interrupt-pending is zero and at least one unmasked source-pending bit is set, the lowest-numbered such bit is loaded into interrupt-pending on the next clock edge. Interrupt-pending never has more than one bit set.
- R6: The offset register (address 3, read-only) holds the bit number of the bit set in interrupt-pending. Writes to it have no effect.
- R7: While interrupt-pending is non-zero, no new winner is loaded. Once it is cleared, arbitration loads the next winner one cycle later.
- R8: `irq` is high exactly when interrupt-pending is non-zero.
- R9: A sub request sets its sub-pending bit. Sub bits 0-2 drive main line 28, bits 3-5 drive main line 23, bits 6-8 drive main line 15, and bits 9-10 drive main line 31. A main line driven by a group is asserted while any sub-pending bit of that group is set with its sub-mask bit clear.
- R10: A sub-mask bit (address 5, 1 = masked) of 1 keeps its sub-pending bit from reaching the main line. Writing 0x7FF masks every sub-source.
- R11: `bus_rdata` returns, one clock after `bus_addr` is presented, the register at that address as it was before that edge. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 32 | Main interrupt requests, sampled every edge |
| sub_req | input | 11 | Secondary interrupt requests, sampled every edge |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt line to the processor |

## Verification
The assertions take for granted that reset is held high for at least one clock edge before any request or write is applied. They also assume that the requests and the bus inputs are stable around each rising edge. The bench changes every input only on falling edges and holds reset over three edges first. Requests are short pulses, so the assertions about write-one-to-clear see both the case where the clear stands alone and the case where a request lands on the same edge as the clear.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SRCPND = 3'd0,
    REG_MASK   = 3'd1,
    REG_INTPND = 3'd2,
    REG_OFFSET = 3'd3,
    REG_SUBPND = 3'd4,
    REG_SUBMSK = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/cic_sub_tier.sv
module cic_sub_tier #(
  parameter int NUM_MAIN = 32,
  parameter int NUM_SUB  = 11,
  parameter int GRP_SIZE = 3,
  parameter int NUM_GRP  = 4,
  parameter logic [NUM_GRP*8-1:0] PARENT_MAP = {8'd31, 8'd15, 8'd23, 8'd28}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SUB-1:0]  sub_req,
  input  logic [NUM_SUB-1:0]  clr_vec,
  input  logic                msk_we,
  input  logic [NUM_SUB-1:0]  msk_wdata,
  output logic [NUM_SUB-1:0]  subpnd,
  output logic [NUM_SUB-1:0]  submsk,
  output logic [NUM_MAIN-1:0] parent_line
);
  logic [NUM_SUB-1:0] active;
  logic [NUM_GRP-1:0] grp_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      subpnd <= '0;
      submsk <= '1;
    end else begin
      subpnd <= (subpnd & ~clr_vec) | sub_req;
      if (msk_we) submsk <= msk_wdata;
    end
  end

  assign active = subpnd & ~submsk;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int LO = g * GRP_SIZE;
    localparam int HI = ((LO + GRP_SIZE) < NUM_SUB ? (LO + GRP_SIZE) : NUM_SUB) - 1;
    if (LO < NUM_SUB) begin : g_live
      assign grp_req[g] = |active[HI:LO];
    end else begin : g_empty
      assign grp_req[g] = 1'b0;
    end
  end

  for (genvar m = 0; m < NUM_MAIN; m++) begin : g_par
    logic [NUM_GRP-1:0] hit;
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_hit
      assign hit[g] = (PARENT_MAP[g*8 +: 8] == 8'(m));
    end
    assign parent_line[m] = |(hit & grp_req);
  end

  // R3: a cleared sub-pending bit with no new request reads zero next cycle
  assert_sub_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((subpnd & $past(clr_vec & ~sub_req)) == '0));

  // R9: a new sub request is always captured
  assert_sub_latch_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((subpnd & $past(sub_req)) == $past(sub_req)));
endmodule

// File: rtl/cic_arbiter.sv
module cic_arbiter #(
  parameter int NUM_MAIN = 32,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_MAIN-1:0] cand,
  input  logic [NUM_MAIN-1:0] clr_vec,
  output logic [NUM_MAIN-1:0] intpnd,
  output logic [IDX_W-1:0]    offset
);
  logic [IDX_W-1:0] win_idx;
  logic             win_vld;

  always_comb begin
    win_idx = '0;
    win_vld = 1'b0;
    for (int i = NUM_MAIN - 1; i >= 0; i--) begin
      if (cand[i]) begin
        win_idx = IDX_W'(i);
        win_vld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intpnd <= '0;
      offset <= '0;
    end else if (intpnd == '0) begin
      if (win_vld) begin
        intpnd <= NUM_MAIN'(1) << win_idx;
        offset <= win_idx;
      end
    end else begin
      intpnd <= intpnd & ~clr_vec;
    end
  end

  assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(intpnd));

  assert_offset_match_R6: assert property (@(posedge clk) disable iff (rst)
    (intpnd != '0) |-> intpnd[offset]);

  assert_lowest_win_R5: assert property (@(posedge clk) disable iff (rst)
    (intpnd == '0 && cand != '0) |=>
      (intpnd != '0 && ($past(cand) & intpnd) != '0 && ($past(cand) & (intpnd - 1'b1)) == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (intpnd != '0 && (intpnd & clr_vec) == '0) |=> (intpnd == $past(intpnd)));
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cic_pkg::*;
#(
  parameter int NUM_MAIN = 32,
  parameter int NUM_SUB  = 11,
  parameter int GRP_SIZE = 3,
  parameter int NUM_GRP  = 4,
  parameter logic [NUM_GRP*8-1:0] PARENT_MAP = {8'd31, 8'd15, 8'd23, 8'd28},
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_MAIN-1:0] src_req,
  input  logic [NUM_SUB-1:0]  sub_req,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq
);
  localparam int IDX_W = $clog2(NUM_MAIN);

  logic [NUM_MAIN-1:0] srcpnd, mask, intpnd, parent_line, cand;
  logic [NUM_MAIN-1:0] clr_src, clr_int;
  logic [NUM_SUB-1:0]  clr_sub, subpnd, submsk;
  logic [IDX_W-1:0]    offset;
  logic                sel_src, sel_int, sel_sub, sel_smk, sel_msk;

  assign sel_src = bus_we && (bus_addr == REG_SRCPND);
  assign sel_msk = bus_we && (bus_addr == REG_MASK);
  assign sel_int = bus_we && (bus_addr == REG_INTPND);
  assign sel_sub = bus_we && (bus_addr == REG_SUBPND);
  assign sel_smk = bus_we && (bus_addr == REG_SUBMSK);

  assign clr_src = sel_src ? bus_wdata[NUM_MAIN-1:0] : '0;
  assign clr_int = sel_int ? bus_wdata[NUM_MAIN-1:0] : '0;
  assign clr_sub = sel_sub ? bus_wdata[NUM_SUB-1:0]  : '0;

  cic_sub_tier #(
    .NUM_MAIN(NUM_MAIN), .NUM_SUB(NUM_SUB), .GRP_SIZE(GRP_SIZE),
    .NUM_GRP(NUM_GRP), .PARENT_MAP(PARENT_MAP)
  ) u_sub (
    .clk(clk), .rst(rst), .sub_req(sub_req), .clr_vec(clr_sub),
    .msk_we(sel_smk), .msk_wdata(bus_wdata[NUM_SUB-1:0]),
    .subpnd(subpnd), .submsk(submsk), .parent_line(parent_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      srcpnd <= '0;
      mask   <= '1;
    end else begin
      srcpnd <= (srcpnd & ~clr_src) | src_req | parent_line;
      if (sel_msk) mask <= bus_wdata[NUM_MAIN-1:0];
    end
  end

  assign cand = srcpnd & ~mask;

  cic_arbiter #(.NUM_MAIN(NUM_MAIN), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst(rst), .cand(cand), .clr_vec(clr_int),
    .intpnd(intpnd), .offset(offset)
  );

  assign irq = |intpnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        REG_SRCPND: bus_rdata <= DATA_W'(srcpnd);
        REG_MASK:   bus_rdata <= DATA_W'(mask);
        REG_INTPND: bus_rdata <= DATA_W'(intpnd);
        REG_OFFSET: bus_rdata <= DATA_W'(offset);
        REG_SUBPND: bus_rdata <= DATA_W'(subpnd);
        REG_SUBMSK: bus_rdata <= DATA_W'(submsk);
        default:    bus_rdata <= '0;
      endcase
    end
  end

  assert_reset_mask_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (mask == '1 && srcpnd == '0 && !irq));

  assert_src_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((srcpnd & $past(clr_src & ~src_req & ~parent_line)) == '0));

  assert_src_latch_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((srcpnd & $past(src_req)) == $past(src_req)));

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(srcpnd & ~mask)));
endmodule

// File: tb/cascade_irq_ctrl_test.sv
module cascade_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_req = '0;
  logic [10:0] sub_req = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [2:0]  a;
    logic [31:0] v;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic rd_req = 1'b0;
  logic rd_cap = 1'b0;

  always #5 clk = ~clk;

  cascade_irq_ctrl uut (
    .clk(clk), .rst(rst), .src_req(src_req), .sub_req(sub_req),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) rd_cap <= rd_req;

  // monitor: pops expected read values as the design returns them
  always @(negedge clk) begin
    if (rd_cap) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (bus_rdata !== e.v) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", e.tag, e.a, bus_rdata, e.v);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = a;
    bus_we = 1'b0;
    rd_req = 1'b1;
    e.a = a; e.v = v; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic pulse_src(input logic [31:0] v);
    @(negedge clk);
    src_req = v;
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic pulse_sub(input logic [10:0] v);
    @(negedge clk);
    sub_req = v;
    @(negedge clk);
    sub_req = '0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic clean_all();
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    idle(2);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int parent[4];
    logic [10:0] subs[4];
    parent = '{28, 23, 15, 31};
    subs = '{11'h001, 11'h010, 11'h080, 11'h400};

    idle(3);
    rst = 1'b0;

    // R1 / R11: reset values and read map
    chk_irq(1'b0, "R1 irq after reset");
    rd(3'd0, 32'h0, "R1 srcpnd reset");
    rd(3'd1, 32'hFFFF_FFFF, "R1 mask reset");
    rd(3'd2, 32'h0, "R1 intpnd reset");
    rd(3'd3, 32'h0, "R1 offset reset");
    rd(3'd4, 32'h0, "R1 subpnd reset");
    rd(3'd5, 32'h0000_07FF, "R1 submask reset");
    rd(3'd7, 32'h0, "R11 unused address");

    // R2 / R4: masked source is latched but does not win
    pulse_src(32'h20);
    idle(2);
    rd(3'd0, 32'h20, "R2 srcpnd latched");
    rd(3'd2, 32'h0, "R4 masked does not win");
    chk_irq(1'b0, "R4 irq stays low");

    // R5 / R8: unmask, winner one clock later
    wr(3'd1, ~32'h20);
    chk_irq(1'b0, "R5 winner not yet loaded");
    @(negedge clk);
    chk_irq(1'b1, "R8 irq follows intpnd");
    rd(3'd2, 32'h20, "R5 intpnd one-hot");
    rd(3'd3, 32'd5, "R6 offset index");

    // R3: clear source then interrupt pending
    wr(3'd0, 32'h20);
    rd(3'd0, 32'h0, "R3 srcpnd cleared");
    wr(3'd2, 32'h20);
    idle(1);
    chk_irq(1'b0, "R3 intpnd cleared");

    // R5: lowest index among several
    wr(3'd1, 32'h0);
    pulse_src(32'h0010_0208);
    idle(2);
    rd(3'd3, 32'd3, "R5 lowest wins offset");
    rd(3'd2, 32'h8, "R5 lowest wins intpnd");

    // R7: no new winner while intpnd busy
    wr(3'd0, 32'h8);
    idle(2);
    rd(3'd2, 32'h8, "R7 held while busy");
    wr(3'd2, 32'h8);
    chk_irq(1'b0, "R7 gap after clear");
    @(negedge clk);
    chk_irq(1'b1, "R7 next winner one cycle later");
    rd(3'd3, 32'd9, "R7 next offset");

    // R3: zero write has no effect, all-ones clears
    wr(3'd2, 32'h0);
    rd(3'd2, 32'h200, "R3 zero write ignored");
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'h0, "R3 all-ones clears srcpnd");
    wr(3'd2, 32'hFFFF_FFFF);
    idle(2);
    chk_irq(1'b0, "R3 all-ones clears intpnd");

    // R10: sub-source masked at reset value
    pulse_sub(11'h010);
    idle(2);
    rd(3'd4, 32'h10, "R9 subpnd latched");
    rd(3'd0, 32'h0, "R10 masked sub blocked");
    chk_irq(1'b0, "R10 irq low while sub masked");

    // R9: unmask sub-sources, group 1 reaches main line 23
    wr(3'd5, 32'h0);
    idle(3);
    rd(3'd3, 32'd23, "R9 group1 to line 23");
    clean_all();

    // R9: each group reaches its parent
    for (int k = 0; k < 4; k++) begin
      pulse_sub(subs[k]);
      idle(3);
      rd(3'd3, 32'(parent[k]), "R9 group parent offset");
      rd(3'd2, 32'h1 << parent[k], "R9 group parent intpnd");
      clean_all();
    end

    // R5 with sub-sources: line 28 beats line 31
    pulse_sub(11'h201);
    idle(3);
    rd(3'd3, 32'd28, "R5 sub groups lowest wins");
    clean_all();
    rd(3'd0, 32'h0, "R3 service sequence leaves srcpnd empty");

    // R6: offset write ignored (last winner was 28)
    wr(3'd3, 32'h7);
    rd(3'd3, 32'd28, "R6 offset write ignored");

    // R10: writing 0x7FF masks everything again
    wr(3'd5, 32'h7FF);
    pulse_sub(11'h7FF);
    idle(3);
    rd(3'd0, 32'h0, "R10 all sub masked");
    chk_irq(1'b0, "R10 irq low");
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'h0, "R3 subpnd all-ones clear");

    // R3: request wins over same-cycle clear
    wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk);
    src_req = 32'h4;
    bus_addr = 3'd0;
    bus_wdata = 32'h4;
    bus_we = 1'b1;
    @(negedge clk);
    src_req = '0;
    bus_we = 1'b0;
    rd(3'd0, 32'h4, "R3 set beats clear");
    chk_irq(1'b0, "R4 masked set bit no irq");

    idle(3);
    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R11 unmatched reads actual=%0d expected=0", sb_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule